// File: doc/BRIEF.md
# Two-Wire Bus FIFO and Interrupt Status Unit

This block sits between a two-wire serial bus byte engine and a host register interface. It buffers bytes in two 8-entry, 8-bit FIFOs. The transmit FIFO is filled by the host and drained by the engine. The receive FIFO is filled by the engine and drained by the host. Each FIFO presents its head byte without a read delay, which is called first-word fall-through.

From the FIFO state and from event pulses sent by the engine, the block builds an 11-bit raw interrupt status vector. Some status bits are level flags computed against programmable 3-bit thresholds, and these follow the FIFO occupancy. The other bits are sticky error and event flags that stay set until they are cleared, either by a per-bit clear strobe or by a clear-all strobe. An abort from the engine empties both FIFOs. A per-bit mask reduces the status vector to a single registered interrupt line.

Top module: `ifs_status_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, all sticky bits are 0, both levels are 0 and `irq` is 0. The bit `raw_status[4]` reads 1, because level 0 is at or below any transmit threshold.
- R2: Both FIFOs keep their bytes in order. A push is accepted only when the level is below 8. A pop is accepted only when the level is above 0. The head byte appears on `eng_tx_data` or `host_rx_data`, `eng_tx_avail` is 1 exactly when the transmit level is nonzero, and each level changes in the cycle after an accepted push or pop.
- R3: `raw_status[0]` (receive underflow) sets in the cycle after `host_rx_rd` is asserted while the receive level is 0.
- R4: `raw_status[1]` (receive overflow) sets in the cycle after `eng_rx_push` is asserted while the receive level is 8. The byte offered in that cycle is discarded.
- R5: `raw_status[2]` (receive threshold) is 1 exactly while the receive level is greater than or equal to `rx_thresh`.
- R6: `raw_status[3]` (transmit overflow) sets in the cycle after `host_tx_wr` is asserted while the transmit level is 8. The byte offered in that cycle is discarded.
- R7: `raw_status[4]` (transmit threshold) is 1 exactly while the transmit level is less than or equal to `tx_thresh`.
- R8: When `ev_abort` is asserted, `raw_status[5]` sets in the next cycle and both FIFOs are empty in the next cycle. Any push or pop offered in the abort cycle is dropped.
- R9: `raw_status[6]` (activity) sets from `ev_activity`. It is cleared by `enable` being low, by `clr_bits[6]`, by `clr_all`, or by reset.
- R10: The event inputs `ev_rd_req`, `ev_rd_done`, `ev_start` and `ev_stop` set the sticky bits `raw_status[7]`, `raw_status[8]`, `raw_status[9]` and `raw_status[10]` respectively.
- R11: A sticky bit is cleared in the next cycle by its `clr_bits` strobe or by `clr_all`. If its set condition occurs in the same cycle as the clear, the bit stays set. Clear strobes on bits 2 and 4 have no effect.
- R12: `irq` equals the OR of `raw_status & irq_mask` as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low clears the activity flag |
| tx_thresh | input | 3 | Transmit threshold level |
| rx_thresh | input | 3 | Receive threshold level |
| irq_mask | input | 11 | Per-bit interrupt mask |
| host_tx_wr | input | 1 | Host writes a byte into the transmit FIFO |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_rd | input | 1 | Host pops the receive FIFO |
| host_rx_data | output | 8 | Receive FIFO head byte |
| eng_tx_pop | input | 1 | Engine pops the transmit FIFO |
| eng_tx_data | output | 8 | Transmit FIFO head byte |
| eng_tx_avail | output | 1 | Transmit FIFO holds at least one byte |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| ev_abort | input | 1 | Transfer abort pulse |
| ev_activity | input | 1 | Bus activity pulse |
| ev_rd_req | input | 1 | Read request event |
| ev_rd_done | input | 1 | Read finished event |
| ev_start | input | 1 | START condition seen |
| ev_stop | input | 1 | STOP condition seen |
| clr_bits | input | 11 | Per-bit clear strobes for sticky status |
| clr_all | input | 1 | Clear all sticky status bits |
| raw_status | output | 11 | Raw interrupt status vector |
| irq | output | 1 | Registered masked interrupt |
| tx_level | output | 4 | Transmit FIFO occupancy |
| rx_level | output | 4 | Receive FIFO occupancy |

## Verification
A wrong occupancy count shows up in the same cycle on the level outputs and on the threshold bits. A wrong count also surfaces later as a missing or spurious overflow or underflow flag, or as a wrong head byte when a pointer drifts from the count. A sticky bit that misses a set, a clear, or the set-over-clear priority differs at `raw_status` one cycle after the stimulus, and at `irq` one cycle after that. The bench therefore compares every output against a queue-based model on each clock, so a divergence is reported within one or two cycles of its cause.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int ST_W        = 11;
  localparam int ST_RX_UNDER = 0;
  localparam int ST_RX_OVER  = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_OVER  = 3;
  localparam int ST_TX_EMPTY = 4;
  localparam int ST_TX_ABORT = 5;
  localparam int ST_ACTIVE   = 6;
  localparam int ST_RD_REQ   = 7;
  localparam int ST_RD_DONE  = 8;
  localparam int ST_START    = 9;
  localparam int ST_STOP     = 10;
  // bits that hold until cleared; the rest follow FIFO levels
  localparam logic [ST_W-1:0] ST_STICKY = 11'b111_1110_1011;
endpackage

// File: rtl/ifs_fifo.sv
module ifs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  input  logic                         flush,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, wr_en;

  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = mem[rd_ptr_q];
  assign level = cnt_q;

  always_comb begin
    do_push  = push & ~full;
    do_pop   = pop & ~empty;
    wr_en    = do_push & ~flush;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/ifs_flag_bank.sv
module ifs_flag_bank #(
  parameter int           N    = 11,
  parameter logic [N-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (KEEP[i]) begin : g_sticky
      logic flag_q, flag_en, unused_lvl;
      assign unused_lvl = lvl[i];
      assign flag_en = set[i] | clr[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (flag_en) flag_q <= set[i];
      end
      assign q[i] = flag_q;
    end else begin : g_live
      logic unused_sc;
      assign unused_sc = set[i] ^ clr[i];
      assign q[i] = lvl[i];
    end
  end
endmodule

// File: rtl/ifs_irq_merge.sv
module ifs_irq_merge #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic irq_d, irq_q;

  always_comb irq_d = |(raw & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/ifs_status_unit.sv
module ifs_status_unit
  import ifs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int THW   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [THW-1:0]             tx_thresh,
  input  logic [THW-1:0]             rx_thresh,
  input  logic [ST_W-1:0]            irq_mask,
  input  logic                       host_tx_wr,
  input  logic [DW-1:0]              host_tx_data,
  input  logic                       host_rx_rd,
  output logic [DW-1:0]              host_rx_data,
  input  logic                       eng_tx_pop,
  output logic [DW-1:0]              eng_tx_data,
  output logic                       eng_tx_avail,
  input  logic                       eng_rx_push,
  input  logic [DW-1:0]              eng_rx_data,
  input  logic                       ev_abort,
  input  logic                       ev_activity,
  input  logic                       ev_rd_req,
  input  logic                       ev_rd_done,
  input  logic                       ev_start,
  input  logic                       ev_stop,
  input  logic [ST_W-1:0]            clr_bits,
  input  logic                       clr_all,
  output logic [ST_W-1:0]            raw_status,
  output logic                       irq,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  output logic [$clog2(DEPTH+1)-1:0] rx_level
);
  localparam int LW = $clog2(DEPTH+1);

  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [ST_W-1:0] set_v, clr_v, lvl_v;
  logic [ST_W-1:0] dis_v;

  ifs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .push(host_tx_wr), .wdata(host_tx_data),
    .pop(eng_tx_pop), .flush(ev_abort),
    .head(eng_tx_data), .level(tx_level),
    .full(tx_full), .empty(tx_empty)
  );

  ifs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(host_rx_rd), .flush(ev_abort),
    .head(host_rx_data), .level(rx_level),
    .full(rx_full), .empty(rx_empty)
  );

  assign eng_tx_avail = ~tx_empty;

  always_comb begin
    set_v              = '0;
    set_v[ST_RX_UNDER] = host_rx_rd & rx_empty;
    set_v[ST_RX_OVER]  = eng_rx_push & rx_full;
    set_v[ST_TX_OVER]  = host_tx_wr & tx_full;
    set_v[ST_TX_ABORT] = ev_abort;
    set_v[ST_ACTIVE]   = ev_activity;
    set_v[ST_RD_REQ]   = ev_rd_req;
    set_v[ST_RD_DONE]  = ev_rd_done;
    set_v[ST_START]    = ev_start;
    set_v[ST_STOP]     = ev_stop;

    dis_v            = '0;
    dis_v[ST_ACTIVE] = ~enable;
    clr_v            = clr_bits | {ST_W{clr_all}} | dis_v;

    lvl_v              = '0;
    lvl_v[ST_RX_FULL]  = (rx_level >= LW'(rx_thresh));
    lvl_v[ST_TX_EMPTY] = (tx_level <= LW'(tx_thresh));
  end

  ifs_flag_bank #(.N(ST_W), .KEEP(ST_STICKY)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set(set_v), .clr(clr_v), .lvl(lvl_v),
    .q(raw_status)
  );

  ifs_irq_merge #(.N(ST_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .raw(raw_status), .mask(irq_mask),
    .irq(irq)
  );
endmodule

// File: rtl/ifs_status_chk.sv
module ifs_status_chk
  import ifs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            host_rx_rd,
  input logic            host_tx_wr,
  input logic            eng_rx_push,
  input logic            eng_tx_pop,
  input logic            ev_abort,
  input logic            ev_activity,
  input logic [ST_W-1:0] clr_bits,
  input logic            clr_all,
  input logic [ST_W-1:0] irq_mask,
  input logic [ST_W-1:0] raw_status,
  input logic            irq,
  input logic [LW-1:0]   tx_level,
  input logic [LW-1:0]   rx_level
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R2

  AST_RX_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_rx_rd && (rx_level == '0) |=> raw_status[ST_RX_UNDER]); // R3

  AST_RX_OVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && (rx_level == LW'(DEPTH)) && !host_rx_rd && !ev_abort
    |=> raw_status[ST_RX_OVER] && (rx_level == LW'(DEPTH))); // R4

  AST_TX_OVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_wr && (tx_level == LW'(DEPTH)) && !eng_tx_pop && !ev_abort
    |=> raw_status[ST_TX_OVER] && (tx_level == LW'(DEPTH))); // R6

  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (tx_level == '0) && (rx_level == '0) && raw_status[ST_TX_ABORT]); // R8

  AST_ACTIVE_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !ev_activity |=> !raw_status[ST_ACTIVE]); // R9

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    raw_status[ST_STOP] && !clr_bits[ST_STOP] && !clr_all |=> raw_status[ST_STOP]); // R10

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all && !ev_abort |=> !raw_status[ST_TX_ABORT]); // R11

  AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(raw_status & irq_mask))); // R12
endmodule

bind ifs_status_unit ifs_status_chk #(.DEPTH(DEPTH), .LW($clog2(DEPTH+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .host_rx_rd(host_rx_rd), .host_tx_wr(host_tx_wr),
  .eng_rx_push(eng_rx_push), .eng_tx_pop(eng_tx_pop),
  .ev_abort(ev_abort), .ev_activity(ev_activity),
  .clr_bits(clr_bits), .clr_all(clr_all), .irq_mask(irq_mask),
  .raw_status(raw_status), .irq(irq),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/sim_ifs_status_unit.sv
`timescale 1ns/1ps
module sim_ifs_status_unit;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  tx_thresh = 3'd0, rx_thresh = 3'd1;
  logic [10:0] irq_mask = '0;
  logic        host_tx_wr = 0, host_rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0]  host_tx_data = '0, eng_rx_data = '0;
  logic        ev_abort = 0, ev_activity = 0, ev_rd_req = 0, ev_rd_done = 0;
  logic        ev_start = 0, ev_stop = 0, clr_all = 0;
  logic [10:0] clr_bits = '0;
  logic [7:0]  host_rx_data, eng_tx_data;
  logic        eng_tx_avail, irq;
  logic [10:0] raw_status;
  logic [3:0]  tx_level, rx_level;

  int n_cmp = 0, n_bad = 0;
  bit checking = 0;

  always #2.5 clk = ~clk;

  ifs_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_mask(irq_mask),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .ev_abort(ev_abort), .ev_activity(ev_activity), .ev_rd_req(ev_rd_req),
    .ev_rd_done(ev_rd_done), .ev_start(ev_start), .ev_stop(ev_stop),
    .clr_bits(clr_bits), .clr_all(clr_all),
    .raw_status(raw_status), .irq(irq),
    .tx_level(tx_level), .rx_level(rx_level)
  );

  // behavioural reference
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [10:0] m_st = '0;
  logic        m_irq = 1'b0;
  logic [10:0] m_raw, m_set;
  int          m_rs, m_ts;
  bit          m_clr;

  function automatic logic [10:0] exp_raw();
    logic [10:0] r;
    r    = m_st & 11'b111_1110_1011;
    r[2] = (rxq.size() >= int'(rx_thresh));
    r[4] = (txq.size() <= int'(tx_thresh));
    return r;
  endfunction

  function automatic string tag_of(int b);
    case (b)
      0: return "R3/R11";
      1: return "R4/R11";
      2: return "R5";
      3: return "R6/R11";
      4: return "R7";
      5: return "R8/R11";
      6: return "R9";
      default: return "R10/R11";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); m_st = '0; m_irq = 1'b0;
    end else begin
      m_raw = exp_raw();
      m_irq = |(m_raw & irq_mask);
      m_rs = rxq.size(); m_ts = txq.size();
      m_set = '0;
      m_set[0] = host_rx_rd && m_rs == 0;
      m_set[1] = eng_rx_push && m_rs == DEPTH;
      m_set[3] = host_tx_wr && m_ts == DEPTH;
      m_set[5] = ev_abort;
      m_set[6] = ev_activity;
      m_set[7] = ev_rd_req;
      m_set[8] = ev_rd_done;
      m_set[9] = ev_start;
      m_set[10] = ev_stop;
      if (ev_abort) begin
        txq.delete(); rxq.delete();
      end else begin
        if (host_rx_rd && m_rs > 0) void'(rxq.pop_front());
        if (eng_rx_push && m_rs < DEPTH) rxq.push_back(eng_rx_data);
        if (eng_tx_pop && m_ts > 0) void'(txq.pop_front());
        if (host_tx_wr && m_ts < DEPTH) txq.push_back(host_tx_data);
      end
      for (int i = 0; i < 11; i++) begin
        m_clr = clr_bits[i] || clr_all || (i == 6 && !enable);
        m_st[i] = m_set[i] || (m_st[i] && !m_clr);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking) begin
      m_raw = exp_raw();
      for (int b = 0; b < 11; b++) chk(tag_of(b), raw_status[b], m_raw[b]);
      chk("R2 tx_level", tx_level, txq.size());
      chk("R2 rx_level", rx_level, rxq.size());
      chk("R2 tx_avail", eng_tx_avail, txq.size() > 0);
      if (txq.size() > 0) chk("R2 tx_head", eng_tx_data, txq[0]);
      if (rxq.size() > 0) chk("R2 rx_head", host_rx_data, rxq[0]);
      chk("R12 irq", irq, m_irq);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    host_tx_wr = 0; host_rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
    ev_abort = 0; ev_activity = 0; ev_rd_req = 0; ev_rd_done = 0;
    ev_start = 0; ev_stop = 0; clr_bits = '0; clr_all = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 raw", raw_status, 11'h010);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 irq", irq, 0);
    checking = 1;
    enable = 1; tx_thresh = 3'd2; rx_thresh = 3'd3; irq_mask = '1;
    tick();
    // R2 R6: fill transmit FIFO past full
    for (int k = 0; k < 10; k++) begin
      host_tx_wr = 1; host_tx_data = 8'h30 + 8'(k); tick();
    end
    for (int k = 0; k < 3; k++) begin eng_tx_pop = 1; tick(); end
    // R4: overfill receive FIFO
    for (int k = 0; k < 9; k++) begin
      eng_rx_push = 1; eng_rx_data = 8'hA0 + 8'(k); tick();
    end
    // R3 R5: drain past empty
    for (int k = 0; k < 10; k++) begin host_rx_rd = 1; tick(); end
    // R11: individual clears, clear of level bits ignored
    clr_bits = 11'b000_0001_1111; tick();
    // R10: events then clears; set wins over clear
    ev_rd_req = 1; ev_rd_done = 1; ev_start = 1; ev_stop = 1; tick();
    clr_bits[9] = 1; ev_stop = 1; clr_bits[10] = 1; tick();
    clr_all = 1; ev_start = 1; tick();
    tick();
    // R9: the four activity clearing paths
    ev_activity = 1; tick(); enable = 0; tick(); enable = 1; tick();
    ev_activity = 1; tick(); clr_bits[6] = 1; tick();
    ev_activity = 1; tick(); clr_all = 1; tick();
    ev_activity = 1; clr_bits[6] = 1; tick(); tick();
    // R8: abort with both FIFOs loaded, push in same cycle dropped
    for (int k = 0; k < 5; k++) begin
      host_tx_wr = 1; host_tx_data = 8'h50 + 8'(k);
      eng_rx_push = 1; eng_rx_data = 8'h60 + 8'(k); tick();
    end
    ev_abort = 1; host_tx_wr = 1; eng_rx_push = 1; tick(); tick();
    // R12: mask patterns
    irq_mask = '0; tick(); tick();
    irq_mask = 11'h020; tick(); tick();
    clr_all = 1; tick(); tick();
    irq_mask = '1;
    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      host_tx_wr   = ($urandom % 100) < 45;
      host_tx_data = 8'($urandom);
      eng_tx_pop   = ($urandom % 100) < 40;
      eng_rx_push  = ($urandom % 100) < 40;
      eng_rx_data  = 8'($urandom);
      host_rx_rd   = ($urandom % 100) < 45;
      ev_abort     = ($urandom % 97) == 0;
      ev_activity  = ($urandom % 9) == 0;
      ev_rd_req    = ($urandom % 13) == 0;
      ev_rd_done   = ($urandom % 17) == 0;
      ev_start     = ($urandom % 11) == 0;
      ev_stop      = ($urandom % 11) == 0;
      clr_bits     = (($urandom % 5) == 0) ? 11'($urandom) : '0;
      clr_all      = ($urandom % 41) == 0;
      if (($urandom % 50) == 0) enable = ~enable;
      if (($urandom % 60) == 0) tx_thresh = 3'($urandom);
      if (($urandom % 60) == 0) rx_thresh = 3'($urandom);
      if (($urandom % 70) == 0) irq_mask = 11'($urandom);
      tick();
    end
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule